// File: doc/BRIEF.md
# Double-Rate Two-Beat Burst SRAM

This block is a small on-chip memory with a read port and a write port that work independently. Both ports are timed by a complementary clock pair, `k` and `k_n`. Each address names a burst of two data words. On the write side the address, the first data beat and its byte mask are taken on the rising edge of `k`. The second beat and its own mask follow on the rising edge of `k_n`. A mask bit that is high keeps the stored byte as it was.

On the read side the address is taken on the rising edge of `k`. The two stored words come back on the output half-cycles that open 1.5 and 2 cycles later. `q_oe` marks the half-cycles in which `q` carries data. When `q_oe` is low the pad driver is off (high impedance) and `q` reads as zero. The read stream has no ready signal and no back-pressure, so the receiver has to take every beat while `q_oe` is high. An echo clock pair, `cq` and `cq_n`, is sent out beside the data and can be used as the capture strobe.

The storage holds 2 × 2^ADDR_W words. The beat index is the least significant bit of the word address.

Top module: `ddrb_sram`

## Requirements
- R1: A read and a write may be issued on the same `k` rising edge, to different addresses, and each completes correctly.
- R2: When `wr_sel_n` is low at a `k` rising edge, `wr_addr` is captured and `wr_data` is stored into the even word (beat index 0) of that burst.
- R3: The `wr_data` present at the following `k_n` rising edge is stored into the odd word (beat index 1) of the same burst.
- R4: `wr_be_n` is active low, one bit per 8-bit lane, and is sampled with each beat. Bit 0 covers bits 7:0 and bit 1 covers bits 15:8. A lane whose bit is high keeps its stored contents. With both bits high, a beat changes nothing.
- R5: When `wr_sel_n` is high at a `k` rising edge, no word changes, whatever is on the write data and mask pins.
- R6: A read sampled at `k` rising edge n drives the even word while `k` is low after edge n+1, and the odd word while `k` is high after edge n+2. `q_oe` is high in both of these half-cycles.
- R7: In every half-cycle that holds no read beat, `q_oe` is low and `q` is zero. This includes the time under reset.
- R8: A read and a write to the same address on the same edge return the newly written data, merged lane by lane with the old contents according to the write masks.
- R9: `cq` follows `k` and `cq_n` follows `k_n`, so a rising echo edge marks the start of each output half-cycle.
- R10: Reads issued on consecutive edges produce an unbroken stream of beats with `q_oe` held high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| k | input | 1 | Positive input clock |
| k_n | input | 1 | Complementary input clock |
| rst_n | input | 1 | Asynchronous active-low reset for control state |
| rd_sel_n | input | 1 | Read select, active low, sampled on `k` rise |
| rd_addr | input | ADDR_W | Read burst address |
| wr_sel_n | input | 1 | Write select, active low, sampled on `k` rise |
| wr_addr | input | ADDR_W | Write burst address |
| wr_data | input | DATA_W | Write data, one beat per clock edge |
| wr_be_n | input | DATA_W/8 | Active-low byte lane write masks, one set per beat |
| q | output | DATA_W | Read data beat |
| q_oe | output | 1 | Output drive enable / beat valid |
| cq | output | 1 | Echo clock, in phase with `k` |
| cq_n | output | 1 | Echo clock, in phase with `k_n` |

## Verification
On every edge of `k`, the assertions check that the read select sampled two edges earlier decides whether the even beat is being driven. They also check that `q` is zero whenever the drive is off and that the echo pair stays complementary. Stored contents can only be shown by the bench's scenarios: lane masking on each beat, ignored writes, same-address merging and back-to-back bursts. The bench compares every output half-cycle against its behavioural model of the memory.

// File: rtl/ddrb_pkg.sv
package ddrb_pkg;
  // beat index within a burst, used as the word address LSB
  typedef enum logic {BEAT_LO = 1'b0, BEAT_HI = 1'b1} beat_e;
  localparam int LANE_W = 8;
endpackage

// File: rtl/ddrb_wr_capture.sv
module ddrb_wr_capture #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 3,
  localparam int NB = DATA_W / ddrb_pkg::LANE_W
) (
  input  logic              k,
  input  logic              rst_n,
  input  logic              wr_sel_n,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [NB-1:0]     wr_be_n,
  output logic              pend,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] beat0_q,
  output logic [NB-1:0]     mask0_q
);
  // first half of a write: address, beat 0 and its mask on k rise
  always_ff @(posedge k or negedge rst_n) begin
    if (!rst_n) begin
      pend    <= 1'b0;
      addr_q  <= '0;
      beat0_q <= '0;
      mask0_q <= '1;
    end else begin
      pend <= !wr_sel_n;
      if (!wr_sel_n) begin
        addr_q  <= wr_addr;
        beat0_q <= wr_data;
        mask0_q <= wr_be_n;
      end
    end
  end
endmodule

// File: rtl/ddrb_array.sv
module ddrb_array
  import ddrb_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 3,
  localparam int NB    = DATA_W / LANE_W,
  localparam int WORDS = 2 * (1 << ADDR_W)
) (
  input  logic              k_n,
  input  logic              wr_go,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] beat0,
  input  logic [NB-1:0]     mask0_n,
  input  logic [DATA_W-1:0] beat1,
  input  logic [NB-1:0]     mask1_n,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_word0,
  output logic [DATA_W-1:0] rd_word1
);
  logic [DATA_W-1:0] mem [WORDS];

  // both beats of a burst commit together on the k_n rise that carries beat 1
  always_ff @(posedge k_n) begin
    if (wr_go) begin
      for (int b = 0; b < NB; b++) begin
        if (!mask0_n[b])
          mem[{wr_addr, BEAT_LO}][b*LANE_W +: LANE_W] <= beat0[b*LANE_W +: LANE_W];
        if (!mask1_n[b])
          mem[{wr_addr, BEAT_HI}][b*LANE_W +: LANE_W] <= beat1[b*LANE_W +: LANE_W];
      end
    end
  end

  assign rd_word0 = mem[{rd_addr, BEAT_LO}];
  assign rd_word1 = mem[{rd_addr, BEAT_HI}];
endmodule

// File: rtl/ddrb_rd_pipe.sv
module ddrb_rd_pipe #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 3
) (
  input  logic              k,
  input  logic              k_n,
  input  logic              rst_n,
  input  logic              rd_sel_n,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] arr_word0,
  input  logic [DATA_W-1:0] arr_word1,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [DATA_W-1:0] q,
  output logic              q_oe
);
  logic              req_vld;
  logic              stg_vld;
  logic [DATA_W-1:0] stg_w0, stg_w1;
  logic              lo_vld, hi_vld;
  logic [DATA_W-1:0] lo_d, hi_d;

  // k domain: address capture, array sample, odd-beat launch
  always_ff @(posedge k or negedge rst_n) begin
    if (!rst_n) begin
      req_vld  <= 1'b0;
      arr_addr <= '0;
      stg_vld  <= 1'b0;
      stg_w0   <= '0;
      stg_w1   <= '0;
      hi_vld   <= 1'b0;
      hi_d     <= '0;
    end else begin
      req_vld <= !rd_sel_n;
      if (!rd_sel_n) arr_addr <= rd_addr;
      stg_vld <= req_vld;
      stg_w0  <= arr_word0;
      stg_w1  <= arr_word1;
      hi_vld  <= stg_vld;
      hi_d    <= stg_w1;
    end
  end

  // k_n domain: even-beat launch
  always_ff @(posedge k_n or negedge rst_n) begin
    if (!rst_n) begin
      lo_vld <= 1'b0;
      lo_d   <= '0;
    end else begin
      lo_vld <= stg_vld;
      lo_d   <= stg_w0;
    end
  end

  // output mux: odd beat while k high, even beat while k low
  logic              drive;
  logic [DATA_W-1:0] beat;
  assign drive = k ? hi_vld : lo_vld;
  assign beat  = k ? hi_d   : lo_d;
  assign q_oe  = drive;
  assign q     = drive ? beat : '0;
endmodule

// File: rtl/ddrb_sram.sv
module ddrb_sram #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 3,
  localparam int NB = DATA_W / ddrb_pkg::LANE_W
) (
  input  logic              k,
  input  logic              k_n,
  input  logic              rst_n,
  input  logic              rd_sel_n,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              wr_sel_n,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [NB-1:0]     wr_be_n,
  output logic [DATA_W-1:0] q,
  output logic              q_oe,
  output logic              cq,
  output logic              cq_n
);
  logic              wr_pend;
  logic [ADDR_W-1:0] wr_addr_q;
  logic [DATA_W-1:0] wr_beat0_q;
  logic [NB-1:0]     wr_mask0_q;
  logic [ADDR_W-1:0] rd_arr_addr;
  logic [DATA_W-1:0] rd_w0, rd_w1;

  ddrb_wr_capture #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_wr (
    .k(k), .rst_n(rst_n), .wr_sel_n(wr_sel_n), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_be_n(wr_be_n), .pend(wr_pend),
    .addr_q(wr_addr_q), .beat0_q(wr_beat0_q), .mask0_q(wr_mask0_q)
  );

  ddrb_array #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_arr (
    .k_n(k_n), .wr_go(wr_pend), .wr_addr(wr_addr_q),
    .beat0(wr_beat0_q), .mask0_n(wr_mask0_q),
    .beat1(wr_data), .mask1_n(wr_be_n),
    .rd_addr(rd_arr_addr), .rd_word0(rd_w0), .rd_word1(rd_w1)
  );

  ddrb_rd_pipe #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rd (
    .k(k), .k_n(k_n), .rst_n(rst_n), .rd_sel_n(rd_sel_n), .rd_addr(rd_addr),
    .arr_word0(rd_w0), .arr_word1(rd_w1), .arr_addr(rd_arr_addr),
    .q(q), .q_oe(q_oe)
  );

  assign cq   = k;
  assign cq_n = k_n;
endmodule

// File: rtl/ddrb_sram_chk.sv
module ddrb_sram_chk #(
  parameter int DATA_W = 16
) (
  input logic              k,
  input logic              k_n,
  input logic              rst_n,
  input logic              rd_sel_n,
  input logic [DATA_W-1:0] q,
  input logic              q_oe,
  input logic              cq,
  input logic              cq_n
);
  AST_EVEN_BEAT_DRIVEN: assert property (@(posedge k) disable iff (!rst_n)
    !rd_sel_n |-> ##2 q_oe); // R6
  AST_IDLE_NO_DRIVE: assert property (@(posedge k) disable iff (!rst_n)
    rd_sel_n |-> ##2 !q_oe); // R7
  AST_OFF_READS_ZERO: assert property (@(posedge k) disable iff (!rst_n)
    !q_oe |-> (q == '0)); // R7
  AST_ECHO_PAIR_K: assert property (@(posedge k) disable iff (!rst_n)
    cq_n == !cq); // R9
  AST_ECHO_PAIR_KN: assert property (@(posedge k_n) disable iff (!rst_n)
    cq_n == !cq); // R9
endmodule

bind ddrb_sram ddrb_sram_chk #(.DATA_W(DATA_W)) u_chk (
  .k(k), .k_n(k_n), .rst_n(rst_n), .rd_sel_n(rd_sel_n),
  .q(q), .q_oe(q_oe), .cq(cq), .cq_n(cq_n)
);

// File: tb/ddrb_sram_tb.sv
module ddrb_sram_tb;
  localparam int DW = 16;
  localparam int AW = 3;
  localparam int NB = 2;

  logic k = 1'b0;
  logic k_n;
  assign k_n = ~k;
  always #10 k = ~k;

  logic          rst_n;
  logic          rd_sel_n, wr_sel_n;
  logic [AW-1:0] rd_addr, wr_addr;
  logic [DW-1:0] wr_data;
  logic [NB-1:0] wr_be_n;
  logic [DW-1:0] q;
  logic          q_oe, cq, cq_n;

  ddrb_sram #(.DATA_W(DW), .ADDR_W(AW)) u_dut (
    .k(k), .k_n(k_n), .rst_n(rst_n), .rd_sel_n(rd_sel_n), .rd_addr(rd_addr),
    .wr_sel_n(wr_sel_n), .wr_addr(wr_addr), .wr_data(wr_data), .wr_be_n(wr_be_n),
    .q(q), .q_oe(q_oe), .cq(cq), .cq_n(cq_n)
  );

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  logic [DW-1:0] mdl [16];
  logic [DW-1:0] exp_d [int];
  string         exp_tag [int];

  task automatic chk(string req, logic [DW:0] act, logic [DW:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // compare one output half-cycle against the model schedule
  task automatic sample(int slot, bit hi_half);
    if (exp_d.exists(slot)) chk(exp_tag[slot], {q_oe, q}, {1'b1, exp_d[slot]});
    else chk("R7 idle", {q_oe, q}, {1'b0, {DW{1'b0}}});
    chk("R9 echo", {{(DW-1){1'b0}}, cq, cq_n}, {{(DW-1){1'b0}}, hi_half, !hi_half});
  endtask

  function automatic logic [DW-1:0] lane_mix(logic [DW-1:0] old, logic [DW-1:0] nw,
                                             logic [NB-1:0] m);
    logic [DW-1:0] r = old;
    for (int b = 0; b < NB; b++) if (!m[b]) r[b*8 +: 8] = nw[b*8 +: 8];
    return r;
  endfunction

  // called in the middle of a k-low half; returns one cycle later
  task automatic op(bit rd, int ra, bit wr, int wa, logic [DW-1:0] d0, logic [NB-1:0] m0,
                    logic [DW-1:0] d1, logic [NB-1:0] m1, string tag);
    rd_sel_n = !rd; rd_addr = AW'(ra);
    wr_sel_n = !wr; wr_addr = AW'(wa);
    wr_data = d0; wr_be_n = m0;
    if (wr) begin
      mdl[2*wa]   = lane_mix(mdl[2*wa], d0, m0);
      mdl[2*wa+1] = lane_mix(mdl[2*wa+1], d1, m1);
    end
    if (rd) begin
      exp_d[2*cyc+3] = mdl[2*ra];   exp_tag[2*cyc+3] = {tag, " R6 even"};
      exp_d[2*cyc+4] = mdl[2*ra+1]; exp_tag[2*cyc+4] = {tag, " R6 odd"};
    end
    #10;
    sample(2*cyc, 1'b1);
    wr_data = d1; wr_be_n = m1;
    #10;
    sample(2*cyc+1, 1'b0);
    cyc++;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) op(0, 0, 0, 0, 16'hDEAD, 2'b00, 16'hBEEF, 2'b00, "idle");
  endtask

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b1; rd_sel_n = 1'b1; wr_sel_n = 1'b1;
    rd_addr = '0; wr_addr = '0; wr_data = '0; wr_be_n = '1;
    #1 rst_n = 1'b0;
    #14;
    chk("R7 reset", {q_oe, q}, {1'b0, {DW{1'b0}}});
    #10;
    chk("R7 reset", {q_oe, q}, {1'b0, {DW{1'b0}}});
    rst_n = 1'b1;

    // R2 R3: fill every burst with full masks
    for (int a = 0; a < 8; a++)
      op(0, 0, 1, a, 16'h1100 + 16'(a), 2'b00, 16'h2200 + 16'(a), 2'b00, "R2 R3 fill");
    // R10: back-to-back reads of all bursts, R2 R3 checked on contents
    for (int a = 0; a < 8; a++)
      op(1, a, 0, 0, '0, 2'b11, '0, 2'b11, "R10 R2 R3 readback");
    idle(3);
    // R4: beat0 lower lane only, beat1 upper lane only
    op(0, 0, 1, 1, 16'hAAAA, 2'b10, 16'hBBBB, 2'b01, "R4 lane");
    op(1, 1, 0, 0, '0, 2'b11, '0, 2'b11, "R4 lane");
    // R4: both lanes masked on both beats
    op(0, 0, 1, 2, 16'hCCCC, 2'b11, 16'hCCCC, 2'b11, "R4 masked");
    op(1, 2, 0, 0, '0, 2'b11, '0, 2'b11, "R4 masked");
    // R5: bus activity with write deselected
    op(0, 0, 0, 6, 16'h5555, 2'b00, 16'h6666, 2'b00, "R5");
    op(1, 6, 0, 0, '0, 2'b11, '0, 2'b11, "R5 ignored");
    // R8: same-edge read and write to one address, partial masks
    op(1, 3, 1, 3, 16'h7777, 2'b01, 16'h8888, 2'b10, "R8 merge");
    idle(1);
    // R1: concurrent read and write to different bursts, then read the write
    op(1, 4, 1, 5, 16'h9999, 2'b00, 16'h4242, 2'b00, "R1 concurrent");
    op(1, 5, 0, 0, '0, 2'b11, '0, 2'b11, "R1 written");
    // boundary burst, write then immediate read on the next edge
    op(0, 0, 1, 7, 16'hF00D, 2'b00, 16'hC0DE, 2'b00, "R2 R3 top");
    op(1, 7, 0, 0, '0, 2'b11, '0, 2'b11, "R2 R3 top");
    idle(4);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule